// File: doc/BRIEF.md
# Divided Local Countdown Timer

This block is a per-core interrupt timer that counts down from a software-loaded start value. A free-running bus-cycle tick feeds it, and a programmable power-of-two prescaler divides that tick. Each time the count runs out, the block records one expiry. In one-shot mode the count then stops at zero. In periodic mode it reloads the start value and keeps going.

Expiries are not held as a single flag. They collect in a small saturating counter of pending ticks. An interrupt request is raised while that counter is nonzero, the timer's vector entry is unmasked and the unit is software-enabled. Each accepted injection, signalled by an acknowledge pulse, removes one pending tick. The surrounding logic decodes register writes and delivers the vector. This block only sees write strobes with their data, the mode and mask bits, and the acknowledge.

Top module: `ltmr_top`

## Requirements
- R1: The 4-bit divide code selects the shift `s = ({code[3], code[1:0]} + 1) mod 8`, and the divisor is 2^s. Code bit 2 has no effect. Code 0000 divides by 2, code 1000 by 32, code 1010 by 128 and code 1011 by 1.
- R2: The count drops by one after every divisor bus ticks. An expiry falls exactly start-value × divisor ticks after the start write. Clock cycles with `bus_tick` low do not advance the count.
- R3: A start-count write loads `cur_count` with the written value on the next cycle and restarts the prescaler phase. It also clears `pend_count`, even if an expiry happens in the same cycle.
- R4: In one-shot mode (`periodic` = 0) the count stays at zero after it expires, and `cur_count` reads 0.
- R5: In periodic mode (`periodic` = 1) the count reloads the last written start value at each expiry and keeps counting.
- R6: Each expiry adds one to `pend_count`. The counter saturates at 2^PEND_W − 1 and does not wrap.
- R7: `irq` is high exactly when `sw_enable` = 1, `masked` = 0 and `pend_count` ≠ 0. An `inj_ack` while `irq` is high removes one pending tick. An `inj_ack` while `irq` is low changes nothing.
- R8: While `sw_enable` = 0, `pend_count` is forced to zero on the next cycle and stays zero, and expiries in that time are dropped.
- R9: A start value of zero leaves the timer idle. No expiry occurs and `cur_count` stays 0.
- R10: After reset, `cur_count` and `pend_count` are 0, `irq` is low, and the divide code is 0000 (divide by 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tick | input | 1 | One bus-cycle tick enable |
| div_wr | input | 1 | Write strobe for the divide code |
| div_code | input | 4 | Divide code written on `div_wr` |
| init_wr | input | 1 | Write strobe for the start count |
| init_count | input | CNT_W | Start count written on `init_wr` |
| periodic | input | 1 | Mode bit from the timer vector entry: 1 = periodic |
| masked | input | 1 | Mask bit from the timer vector entry |
| sw_enable | input | 1 | Software enable of the interrupt unit |
| inj_ack | input | 1 | Injection accepted; consumes one pending tick |
| cur_count | output | CNT_W | Remaining count |
| pend_count | output | PEND_W | Pending expiries |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 16 and PEND_W = 2. A pending maximum of 3 lets a periodic run with a start value of 2 reach saturation within twenty cycles, and lets a one-tick periodic run reach it within three. The short count width keeps every run brief. The longest checks, at the ÷32 and ÷128 settings, still finish in about a hundred cycles. Together they cover all three code bits, including the wraparound code and the ignored bit 2.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    localparam int DIV_CODE_W = 4;
    localparam int SHIFT_W    = 3;
    localparam int PRESCALE_W = (1 << SHIFT_W) - 1;

    typedef logic [SHIFT_W-1:0]    shift_t;
    typedef logic [DIV_CODE_W-1:0] div_code_t;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_PERIODIC = 1'b1
    } tmode_e;

    // Bits 3,1,0 form a 3-bit selector; adding one wraps so 3'b111 -> shift 0.
    function automatic shift_t code_to_shift(input div_code_t code);
        shift_t sel;
        sel = {code[3], code[1:0]};
        return shift_t'(sel + shift_t'(1));
    endfunction

endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
    import ltmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      div_wr,
    input  div_code_t div_code,
    input  logic      restart,
    input  logic      bus_tick,
    output logic      step_o
);

    typedef struct packed {
        shift_t                shift;
        logic [PRESCALE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRESCALE_W-1:0] limit;
    logic                  at_limit;

    always_comb begin
        limit    = {PRESCALE_W{1'b1}} >> (shift_t'(PRESCALE_W) - st_q.shift);
        at_limit = (st_q.phase == limit);
        step_o   = bus_tick && at_limit && !restart && !div_wr;

        st_d = st_q;
        if (div_wr) begin
            st_d.shift = code_to_shift(div_code);
        end
        if (restart || div_wr) begin
            st_d.phase = '0;
        end else if (bus_tick) begin
            st_d.phase = at_limit ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shift <= code_to_shift('0);
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ltmr_down.sv
module ltmr_down
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  tmode_e           mode,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
    } down_state_t;

    down_state_t st_d, st_q;

    always_comb begin
        expire_o = step && !load && (st_q.count == ONE);

        st_d = st_q;
        if (load) begin
            st_d.count  = load_val;
            st_d.reload = load_val;
        end else if (step && (st_q.count != '0)) begin
            if (st_q.count == ONE) begin
                st_d.count = (mode == MODE_PERIODIC) ? st_q.reload : '0;
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/ltmr_pend.sv
module ltmr_pend #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              expire,
    input  logic              ack,
    input  logic              masked,
    input  logic              enable,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o
);

    localparam logic [PEND_W:0] PEND_MAX = {1'b0, {PEND_W{1'b1}}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } pend_state_t;

    pend_state_t     st_d, st_q;
    logic            consume;
    logic [PEND_W:0] sum;

    always_comb begin
        irq_o   = enable && !masked && (st_q.pend != '0);
        consume = irq_o && ack;
        sum     = {1'b0, st_q.pend} + {{PEND_W{1'b0}}, expire}
                - {{PEND_W{1'b0}}, consume};

        st_d = st_q;
        if (clear) begin
            st_d.pend = '0;
        end else if (sum > PEND_MAX) begin
            st_d.pend = PEND_MAX[PEND_W-1:0];
        end else begin
            st_d.pend = sum[PEND_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
    import ltmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              div_wr,
    input  logic [3:0]        div_code,
    input  logic              init_wr,
    input  logic [CNT_W-1:0]  init_count,
    input  logic              periodic,
    input  logic              masked,
    input  logic              sw_enable,
    input  logic              inj_ack,
    output logic [CNT_W-1:0]  cur_count,
    output logic [PEND_W-1:0] pend_count,
    output logic              irq
);

    logic   step_w;
    logic   expire_w;
    logic   pend_clear;
    tmode_e mode_w;

    assign mode_w     = tmode_e'(periodic);
    assign pend_clear = init_wr || !sw_enable;

    ltmr_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_code (div_code),
        .restart  (init_wr),
        .bus_tick (bus_tick),
        .step_o   (step_w)
    );

    ltmr_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_count),
        .step     (step_w),
        .mode     (mode_w),
        .count_o  (cur_count),
        .expire_o (expire_w)
    );

    ltmr_pend #(.PEND_W(PEND_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pend_clear),
        .expire (expire_w),
        .ack    (inj_ack),
        .masked (masked),
        .enable (sw_enable),
        .pend_o (pend_count),
        .irq_o  (irq)
    );

endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_tick,
    input logic              init_wr,
    input logic [CNT_W-1:0]  init_count,
    input logic              sw_enable,
    input logic              inj_ack,
    input logic [CNT_W-1:0]  cur_count,
    input logic [PEND_W-1:0] pend_count,
    input logic              irq,
    input logic              expire
);

    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tick && !init_wr) |=> $stable(cur_count));

    assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur_count == $past(init_count)) && (pend_count == '0));

    assert_oneshot_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_wr) |=> (cur_count == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == PMAX && sw_enable && !init_wr && !(irq && inj_ack))
        |=> (pend_count == PMAX));

    assert_ack_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && inj_ack && !init_wr && !expire)
        |=> (pend_count == PEND_W'($past(pend_count) - 1'b1)));

    assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> (pend_count == '0));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0) |-> !expire);

endmodule

bind ltmr_top ltmr_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_tick   (bus_tick),
    .init_wr    (init_wr),
    .init_count (init_count),
    .sw_enable  (sw_enable),
    .inj_ack    (inj_ack),
    .cur_count  (cur_count),
    .pend_count (pend_count),
    .irq        (irq),
    .expire     (expire_w)
);

// File: tb/ltmr_top_tb.sv
module ltmr_top_tb;

    localparam int CW = 16;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_tick = 1'b1;
    logic          div_wr = 1'b0;
    logic [3:0]    div_code = '0;
    logic          init_wr = 1'b0;
    logic [CW-1:0] init_count = '0;
    logic          periodic = 1'b0;
    logic          masked = 1'b1;
    logic          sw_enable = 1'b1;
    logic          inj_ack = 1'b0;
    logic [CW-1:0] cur_count;
    logic [PW-1:0] pend_count;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ltmr_top #(.CNT_W(CW), .PEND_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .div_wr(div_wr),
        .div_code(div_code), .init_wr(init_wr), .init_count(init_count),
        .periodic(periodic), .masked(masked), .sw_enable(sw_enable),
        .inj_ack(inj_ack), .cur_count(cur_count), .pend_count(pend_count),
        .irq(irq)
    );

    typedef struct packed {
        logic [3:0]    code;
        logic [CW-1:0] start;
        logic          per;
        logic [7:0]    wait_n;
        logic [CW-1:0] exp_cnt;
        logic [PW-1:0] exp_pend;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 16'd5, 1'b0, 8'd10,  16'd0, 2'd1},
        '{4'b0001, 16'd3, 1'b0, 8'd6,   16'd2, 2'd0},
        '{4'b1011, 16'd4, 1'b0, 8'd4,   16'd0, 2'd1},
        '{4'b1011, 16'd4, 1'b1, 8'd9,   16'd3, 2'd2},
        '{4'b0100, 16'd3, 1'b0, 8'd5,   16'd1, 2'd0},
        '{4'b1000, 16'd2, 1'b0, 8'd64,  16'd0, 2'd1},
        '{4'b1010, 16'd1, 1'b0, 8'd127, 16'd1, 2'd0},
        '{4'b1011, 16'd2, 1'b1, 8'd20,  16'd2, 2'd3},
        '{4'b1011, 16'd0, 1'b0, 8'd10,  16'd0, 2'd0},
        '{4'b0010, 16'd2, 1'b0, 8'd16,  16'd0, 2'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic wr_div, input logic [3:0] code,
                        input logic [CW-1:0] start, input logic per);
        @(negedge clk);
        div_wr     = wr_div;
        div_code   = code;
        init_wr    = 1'b1;
        init_count = start;
        periodic   = per;
        @(negedge clk);
        div_wr  = 1'b0;
        init_wr = 1'b0;
    endtask

    task automatic step_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step_n(2);
        // R10: reset values
        check("R10 count after reset", int'(cur_count), 0);
        check("R10 pend after reset", int'(pend_count), 0);
        check("R10 irq after reset", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 count after release", int'(cur_count), 0);

        // R10: default divide by 2, start 3, no divide write
        load(1'b0, 4'b0000, 16'd3, 1'b0);
        step_n(5);
        check("R10 default divider count", int'(cur_count), 1);
        step_n(1);
        check("R10 default divider expiry", int'(pend_count), 1);

        // R1 R2 R4 R5 R6 R9: vector table
        for (int i = 0; i < NV; i++) begin
            load(1'b1, VECS[i].code, VECS[i].start, VECS[i].per);
            step_n(int'(VECS[i].wait_n));
            check($sformatf("R1/R2 vec%0d count", i), int'(cur_count), int'(VECS[i].exp_cnt));
            check($sformatf("R6 vec%0d pend", i), int'(pend_count), int'(VECS[i].exp_pend));
        end

        // R7: unmasked with one pending -> irq, ack consumes
        load(1'b1, 4'b1011, 16'd1, 1'b0);
        step_n(1);
        check("R4 oneshot rest", int'(cur_count), 0);
        check("R7 masked no irq", int'(irq), 0);
        inj_ack = 1'b1;
        step_n(1);
        inj_ack = 1'b0;
        check("R7 ack while masked ignored", int'(pend_count), 1);
        masked = 1'b0;
        step_n(1);
        check("R7 irq when unmasked", int'(irq), 1);
        inj_ack = 1'b1;
        step_n(1);
        inj_ack = 1'b0;
        check("R7 ack consumes", int'(pend_count), 0);
        check("R7 irq drops", int'(irq), 0);

        // R8: disable zeroes pending and drops expiries
        load(1'b1, 4'b1011, 16'd1, 1'b0);
        step_n(1);
        check("R8 pend before disable", int'(pend_count), 1);
        sw_enable = 1'b0;
        step_n(1);
        check("R8 pend cleared", int'(pend_count), 0);
        check("R8 irq low", int'(irq), 0);
        load(1'b1, 4'b1011, 16'd1, 1'b1);
        step_n(5);
        check("R8 expiries dropped", int'(pend_count), 0);
        sw_enable = 1'b1;
        step_n(3);
        check("R6 saturation", int'(pend_count), 3);
        check("R5 periodic reload", int'(cur_count), 1);

        // R3: start write mid-run reloads and clears pending
        load(1'b1, 4'b1011, 16'd6, 1'b0);
        check("R3 count loaded", int'(cur_count), 6);
        check("R3 pend cleared", int'(pend_count), 0);

        // R2: cycles without bus tick do not advance
        step_n(3);
        check("R2 count ticking", int'(cur_count), 3);
        bus_tick = 1'b0;
        step_n(5);
        check("R2 count held without tick", int'(cur_count), 3);
        bus_tick = 1'b1;
        step_n(2);
        check("R2 count resumes", int'(cur_count), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule